// File: doc/BRIEF.md
# Saturating Rounding Variable Shifter

This unit shifts every element of a 64-bit vector word by its own signed count. The elements can be 8, 16, 32 or 64 bits wide. A positive count shifts left and a negative count shifts right. Control inputs choose three further things:
- how the source bits are read: signed, unsigned, or signed source with an unsigned result;
- whether right shifts round;
- whether left shifts that overflow clamp to a limit or wrap.

The block returns the shifted word one cycle after a valid input. It also keeps a sticky flag that records any clamping since the flag was last cleared.

A typical user is a vector execute stage. It places the sources in `data_i` and the per-lane counts in `shamt_i`, then pulses `in_valid_i`. It reads `data_o` when `out_valid_o` is high. It polls `sat_o` and clears it with `sat_clr_i` at the boundaries its architecture defines.

Top module: `vshift_sat`

## Requirements
- R1: `out_valid_o` is `in_valid_i` delayed by one cycle. `data_o` takes the result of every valid input one cycle later, with all lanes updating together, and holds its value in every other cycle. Reset gives `data_o` = 0, `out_valid_o` = 0 and `sat_o` = 0.
- R2: `esize_i` codes 0, 1, 2 and 3 select 8, 16, 32 and 64-bit elements. The count for each lane is the signed 8-bit value in bits [7:0] of the matching lane of `shamt_i`. All other bits of `shamt_i` are ignored. Lanes are computed independently.
- R3: `mode_i` code 0 is signed, 1 is unsigned, 2 is signed-to-unsigned, and 3 acts as unsigned. A count c with 0 <= c < W shifts the source left by c places. When the result does not overflow, it is returned exactly.
- R4: A count -n with 1 <= n < W and rounding off gives an arithmetic right shift by n in signed mode and a logical right shift by n otherwise.
- R5: With `round_i` = 1, a right shift by n first shifts by n-1. It then shifts one more place and adds the last bit shifted out, so halves round up.
- R6: In signed mode, a count <= -W gives 0 when rounding is on. When rounding is off it gives the sign fill: all ones for a negative source and 0 otherwise.
- R7: In unsigned mode, a count <= -(W + round_i) gives 0. With rounding on, a count of exactly -W returns the source's top bit.
- R8: With `sat_en_i` = 1, a left shift by c < W overflows when shifting the result back right by c (arithmetic for signed, logical for unsigned) does not give the source. The result then clamps and the lane sets the flag. Signed clamping gives the largest positive value for a non-negative source and the most negative value for a negative source. Unsigned clamping gives all ones.
- R9: With `sat_en_i` = 0, an overflowing left shift returns the wrapped, truncated value, and a count >= W gives 0. Neither case changes `sat_o`.
- R10: With `sat_en_i` = 1, a count >= W gives 0 without setting the flag when the source is zero. For any other source it clamps as in R8 and sets the flag.
- R11: In mode 2 with `sat_en_i` = 1, a negative source lane gives 0 and sets the flag. In every other case mode 2 gives the same result as unsigned mode.
- R12: `sat_o` becomes 1 one cycle after any valid input in which some lane clamped. It stays 1 until a cycle with `sat_clr_i` = 1, after which it is 0. If a clear and a clamping input arrive in the same cycle, `sat_o` ends at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input word valid |
| esize_i | input | 2 | Element size code (0:8, 1:16, 2:32, 3:64) |
| mode_i | input | 2 | Signedness code (0 signed, 1 unsigned, 2 signed-to-unsigned, 3 unsigned) |
| round_i | input | 1 | Round right shifts |
| sat_en_i | input | 1 | Clamp instead of wrap |
| sat_clr_i | input | 1 | Clear the sticky flag |
| data_i | input | 64 | Source elements |
| shamt_i | input | 64 | Per-lane counts in the low byte of each lane |
| out_valid_o | output | 1 | Result valid |
| data_o | output | 64 | Shifted elements |
| sat_o | output | 1 | Sticky clamp flag |

## Verification
The assertions check the following on every cycle:
- the one-cycle valid delay and the holding of `data_o` between valid inputs;
- the stickiness and clearing of the flag;
- that an all-zero count passes the source through;
- that a disabled clamp never raises the flag;
- that a negative 64-bit source in signed-to-unsigned clamping mode yields zero with the flag set.

The numeric behaviour needs the bench's chosen vectors to show it. That covers rounding at the half point, the sign fill versus zero at large negative counts, the unsigned -W rounding case, the overflow rule in each signedness, and the zero-source exemption at large positive counts.

// File: rtl/vshift_pkg.sv
package vshift_pkg;
  localparam int VEC_W   = 64;
  localparam int CNT_W   = 8;
  localparam int MIN_EW  = 8;
  localparam int NUM_SZ  = $clog2(VEC_W / MIN_EW) + 1;

  typedef enum logic [1:0] {
    MODE_SIGNED   = 2'd0,
    MODE_UNSIGNED = 2'd1,
    MODE_S2U      = 2'd2,
    MODE_UNS_ALT  = 2'd3
  } mode_e;
endpackage

// File: rtl/vshift_lane.sv
module vshift_lane
  import vshift_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0]     src_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  mode_e            mode_i,
  input  logic             round_i,
  input  logic             sat_en_i,
  output logic [W-1:0]     res_o,
  output logic             sat_o
);
  localparam int SH_W = $clog2(W) + 1;

  always_comb begin
    int              cv;
    logic [SH_W-1:0] sh;
    logic [W-1:0]    t;
    logic [W-1:0]    v;
    logic            neg;
    logic            ovf;
    cv    = int'($signed(cnt_i));
    neg   = src_i[W-1];
    sh    = '0;
    t     = '0;
    v     = '0;
    ovf   = 1'b0;
    res_o = '0;
    sat_o = 1'b0;
    if (mode_i == MODE_S2U && sat_en_i && neg) begin
      sat_o = 1'b1;
    end else if (mode_i == MODE_SIGNED) begin
      if (cv <= -W) begin
        res_o = round_i ? '0 : {W{neg}};
      end else if (cv < 0) begin
        if (round_i) begin
          sh    = SH_W'(-cv - 1);
          t     = W'($signed(src_i) >>> sh);
          res_o = W'($signed(t) >>> 1) + W'(t[0]);
        end else begin
          sh    = SH_W'(-cv);
          res_o = W'($signed(src_i) >>> sh);
        end
      end else if (cv < W) begin
        sh = SH_W'(cv);
        v  = src_i << sh;
        if (!sat_en_i || W'($signed(v) >>> sh) == src_i) res_o = v;
        else ovf = 1'b1;
      end else if (sat_en_i && src_i != '0) begin
        ovf = 1'b1;
      end
      if (ovf) begin
        sat_o = 1'b1;
        res_o = neg ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
      end
    end else begin
      // unsigned path; signed-to-unsigned with non-negative source lands here
      if (cv <= -(W + int'(round_i))) begin
        res_o = '0;
      end else if (cv < 0) begin
        if (round_i) begin
          sh    = SH_W'(-cv - 1);
          t     = src_i >> sh;
          res_o = (t >> 1) + W'(t[0]);
        end else begin
          sh    = SH_W'(-cv);
          res_o = src_i >> sh;
        end
      end else if (cv < W) begin
        sh = SH_W'(cv);
        v  = src_i << sh;
        if (!sat_en_i || (v >> sh) == src_i) res_o = v;
        else ovf = 1'b1;
      end else if (sat_en_i && src_i != '0) begin
        ovf = 1'b1;
      end
      if (ovf) begin
        sat_o = 1'b1;
        res_o = '1;
      end
    end
  end
endmodule

// File: rtl/vshift_sat.sv
module vshift_sat
  import vshift_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  input  logic [1:0]       esize_i,
  input  logic [1:0]       mode_i,
  input  logic             round_i,
  input  logic             sat_en_i,
  input  logic             sat_clr_i,
  input  logic [VEC_W-1:0] data_i,
  input  logic [VEC_W-1:0] shamt_i,
  output logic             out_valid_o,
  output logic [VEC_W-1:0] data_o,
  output logic             sat_o
);
  logic [NUM_SZ-1:0][VEC_W-1:0] res_sz;
  logic [NUM_SZ-1:0]            sat_sz;
  logic [VEC_W-1:0]             res_sel;
  logic                         sat_sel;
  mode_e                        mode;

  assign mode = mode_e'(mode_i);

  for (genvar g = 0; g < NUM_SZ; g++) begin : g_sz
    localparam int EW = MIN_EW << g;
    localparam int NL = VEC_W / EW;
    logic [NL-1:0] sat_l;
    for (genvar l = 0; l < NL; l++) begin : g_lane
      vshift_lane #(.W(EW)) u_lane (
        .src_i    (data_i[l*EW +: EW]),
        .cnt_i    (shamt_i[l*EW +: CNT_W]),
        .mode_i   (mode),
        .round_i  (round_i),
        .sat_en_i (sat_en_i),
        .res_o    (res_sz[g][l*EW +: EW]),
        .sat_o    (sat_l[l])
      );
    end
    assign sat_sz[g] = |sat_l;
  end

  assign res_sel = res_sz[esize_i];
  assign sat_sel = sat_sz[esize_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      data_o      <= '0;
      sat_o       <= 1'b0;
    end else begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) data_o <= res_sel;
      // a clamp in the clearing cycle is kept
      sat_o <= (sat_o & ~sat_clr_i) | (in_valid_i & sat_sel);
    end
  end

  p_valid_lat_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o == $past(in_valid_i));

  p_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(in_valid_i) |-> $stable(data_o));

  p_zero_cnt_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(in_valid_i && shamt_i == '0 && !(mode_i == MODE_S2U && sat_en_i))
      |-> data_o == $past(data_i));

  p_no_clamp_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(in_valid_i && !sat_en_i && !sat_o) |-> !sat_o);

  p_s2u_neg_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(in_valid_i && mode_i == MODE_S2U && sat_en_i && esize_i == 2'd3 && data_i[VEC_W-1])
      |-> (sat_o && data_o == '0));

  p_sticky_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(sat_o) && !$past(sat_clr_i) |-> sat_o);

  p_clear_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(sat_clr_i) && !$past(in_valid_i) |-> !sat_o);
endmodule

// File: tb/vshift_sat_test.sv
`timescale 1ns/1ps
module vshift_sat_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0;
  logic [1:0]  esize_i = '0;
  logic [1:0]  mode_i = '0;
  logic        round_i = 1'b0;
  logic        sat_en_i = 1'b0;
  logic        sat_clr_i = 1'b0;
  logic [63:0] data_i = '0;
  logic [63:0] shamt_i = '0;
  logic        out_valid_o;
  logic [63:0] data_o;
  logic        sat_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  vshift_sat uut (.*);

  typedef struct packed {
    logic [1:0]  es;
    logic [1:0]  md;
    logic        rnd;
    logic        sat;
    logic [63:0] d;
    logic [63:0] s;
    logic [63:0] e;
    logic        ef;
    logic [7:0]  rq;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t TBL [NV] = '{
    // R3 8-bit unsigned left by 1
    '{2'd0, 2'd1, 1'b0, 1'b1, 64'h0102030405060708, 64'h0101010101010101, 64'h020406080A0C0E10, 1'b0, 8'd3},
    // R2 16-bit signed, own count per lane, high count byte ignored
    '{2'd1, 2'd0, 1'b0, 1'b1, 64'h0001FFFF00108000, 64'h7F037F007F047FFF, 64'h0008FFFF0100C000, 1'b0, 8'd2},
    // R4 32-bit logical right
    '{2'd2, 2'd1, 1'b0, 1'b0, 64'hF000000000000007, 64'h000000FC000000FF, 64'h0F00000000000003, 1'b0, 8'd4},
    // R4 32-bit arithmetic right
    '{2'd2, 2'd0, 1'b0, 1'b0, 64'hF000000000000007, 64'h000000FC000000FF, 64'hFF00000000000003, 1'b0, 8'd4},
    // R5 8-bit signed rounding right
    '{2'd0, 2'd0, 1'b1, 1'b0, 64'h000000000506FB07, 64'h00000000FEFEFFFF, 64'h000000000102FE04, 1'b0, 8'd5},
    // R6 signed count <= -8, no rounding: sign fill
    '{2'd0, 2'd0, 1'b0, 1'b0, 64'h0000000000FF7F80, 64'h000000000080F8F8, 64'h0000000000FF00FF, 1'b0, 8'd6},
    // R6 same with rounding: zero
    '{2'd0, 2'd0, 1'b1, 1'b0, 64'h0000000000FF7F80, 64'h000000000080F8F8, 64'h0000000000000000, 1'b0, 8'd6},
    // R7 unsigned rounding: -8 gives top bit, -9 gives 0
    '{2'd0, 2'd1, 1'b1, 1'b0, 64'h0000000080FF7F80, 64'h00000000F9F7F8F8, 64'h0000000001000001, 1'b0, 8'd7},
    // R7 unsigned truncating: -8 gives 0
    '{2'd0, 2'd1, 1'b0, 1'b0, 64'h0000000080FF7F80, 64'h00000000F9F7F8F8, 64'h0000000001000000, 1'b0, 8'd7},
    // R8 16-bit signed clamp both ways, one lane fits
    '{2'd1, 2'd0, 1'b0, 1'b1, 64'h0000A000C0004000, 64'h0000000100010001, 64'h0000800080007FFF, 1'b1, 8'd8},
    // R9 same without clamping: wrapped
    '{2'd1, 2'd0, 1'b0, 1'b0, 64'h0000A000C0004000, 64'h0000000100010001, 64'h0000400080008000, 1'b0, 8'd9},
    // R8 32-bit unsigned clamp
    '{2'd2, 2'd1, 1'b0, 1'b1, 64'h8000000140000000, 64'h0000000100000001, 64'hFFFFFFFF80000000, 1'b1, 8'd8},
    // R10 count >= 8 with clamping
    '{2'd0, 2'd0, 1'b0, 1'b1, 64'h0000000000800100, 64'h00000000007F0808, 64'h0000000000807F00, 1'b1, 8'd10},
    // R10 zero source, count >= 8: no flag
    '{2'd0, 2'd0, 1'b0, 1'b1, 64'h0000000000000000, 64'h0808080808080808, 64'h0000000000000000, 1'b0, 8'd10},
    // R9 count >= 8 without clamping: zero
    '{2'd0, 2'd0, 1'b0, 1'b0, 64'h0000000000800100, 64'h00000000007F0808, 64'h0000000000000000, 1'b0, 8'd9},
    // R11 signed-to-unsigned, negative source
    '{2'd3, 2'd2, 1'b0, 1'b1, 64'h8000000000000000, 64'h0000000000000000, 64'h0000000000000000, 1'b1, 8'd11},
    // R11 signed-to-unsigned, positive source uses unsigned overflow rule
    '{2'd3, 2'd2, 1'b0, 1'b1, 64'h4000000000000001, 64'h0000000000000001, 64'h8000000000000002, 1'b0, 8'd11},
    // R8 signed 64-bit clamp of same input
    '{2'd3, 2'd0, 1'b0, 1'b1, 64'h4000000000000001, 64'h0000000000000001, 64'h7FFFFFFFFFFFFFFF, 1'b1, 8'd8},
    // R11 signed-to-unsigned without clamping: logical right
    '{2'd3, 2'd2, 1'b0, 1'b0, 64'h8000000000000000, 64'h00000000000000FF, 64'h4000000000000000, 1'b0, 8'd11},
    // R4 64-bit arithmetic right by 63
    '{2'd3, 2'd0, 1'b0, 1'b0, 64'h8000000000000000, 64'h00000000000000C1, 64'hFFFFFFFFFFFFFFFF, 1'b0, 8'd4},
    // R10 64-bit unsigned count 64
    '{2'd3, 2'd1, 1'b0, 1'b1, 64'h0000000000000001, 64'h0000000000000040, 64'hFFFFFFFFFFFFFFFF, 1'b1, 8'd10}
  };

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  // one input cycle, outputs sampled at the next falling edge
  task automatic op(input logic [1:0] es, input logic [1:0] md, input logic rnd,
                    input logic sat, input logic [63:0] d, input logic [63:0] s,
                    input logic clr, input logic vld);
    @(negedge clk_i);
    esize_i = es; mode_i = md; round_i = rnd; sat_en_i = sat;
    data_i = d; shamt_i = s; sat_clr_i = clr; in_valid_i = vld;
    @(negedge clk_i);
    in_valid_i = 1'b0; sat_clr_i = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 reset valid", 64'(out_valid_o), 64'd0);
    chk("R1 reset data", data_o, 64'd0);
    chk("R1 reset flag", 64'(sat_o), 64'd0);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      op(TBL[i].es, TBL[i].md, TBL[i].rnd, TBL[i].sat, TBL[i].d, TBL[i].s, 1'b1, 1'b1);
      chk($sformatf("R%0d row %0d data", TBL[i].rq, i), data_o, TBL[i].e);
      chk($sformatf("R%0d row %0d flag", TBL[i].rq, i), 64'(sat_o), 64'(TBL[i].ef));
      chk($sformatf("R1 row %0d valid", i), 64'(out_valid_o), 64'd1);
    end

    // R1: output held and valid low with no input
    @(negedge clk_i);
    chk("R1 valid drop", 64'(out_valid_o), 64'd0);
    chk("R1 data held", data_o, 64'hFFFFFFFFFFFFFFFF);
    op(2'd0, 2'd1, 1'b0, 1'b0, 64'h1111111111111111, 64'h0101010101010101, 1'b0, 1'b0);
    chk("R1 invalid ignored", data_o, 64'hFFFFFFFFFFFFFFFF);

    // R12 sticky flag
    op(2'd0, 2'd0, 1'b0, 1'b0, 64'd0, 64'd0, 1'b1, 1'b0);
    chk("R12 clear", 64'(sat_o), 64'd0);
    op(2'd1, 2'd0, 1'b0, 1'b1, 64'h0000000000004000, 64'h0000000000000001, 1'b0, 1'b1);
    chk("R12 set", 64'(sat_o), 64'd1);
    op(2'd1, 2'd0, 1'b0, 1'b1, 64'h0000000000000001, 64'h0000000000000001, 1'b0, 1'b1);
    chk("R12 keep data", data_o, 64'h0000000000000002);
    chk("R12 keep flag", 64'(sat_o), 64'd1);
    op(2'd0, 2'd0, 1'b0, 1'b0, 64'd0, 64'd0, 1'b1, 1'b0);
    chk("R12 clear again", 64'(sat_o), 64'd0);
    op(2'd1, 2'd0, 1'b0, 1'b1, 64'h0000000000004000, 64'h0000000000000001, 1'b1, 1'b1);
    chk("R12 set wins over clear", 64'(sat_o), 64'd1);
    finish_run();
  end
endmodule